// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic core of a small accumulator-style processor. It holds an 8-bit accumulator, a second working register and a status word with carry, auxiliary carry and overflow bits. Each clock cycle it can perform one operation, chosen by an opcode. The second operand is taken either from the working register or from an external data input.

The operation set covers the following:
- add with and without carry-in, and subtract with borrow
- bitwise logic
- increment and decrement
- plain rotates and rotates through carry
- nibble swap, clear and complement
- decimal adjust after a BCD addition
- an unsigned 8x8 multiply and an 8/8 divide

The result of the current opcode is also shown on a combinational output, so an increment or decrement of an external byte can be returned to the surrounding logic without disturbing the accumulator. Parity always follows the accumulator contents.

Top module: `acc_alu`

## Requirements
- R1: After reset the accumulator, the working register and the carry, auxiliary-carry and overflow flags are all zero, and parity reads 0.
- R2: The operand is the working register when `opndSel`=0 and `extIn` when `opndSel`=1. Opcode 1 loads the operand into the accumulator. Opcode 2 loads it into the working register. Opcode 3 loads the flags from the operand: carry from bit 7, auxiliary carry from bit 6, overflow from bit 2.
- R3: Opcode 4 computes acc+operand and opcode 5 computes acc+operand+carry, both into the accumulator. Carry is the carry out of bit 7 and auxiliary carry is the carry out of bit 3. Overflow is set when both inputs share bit 7 and the result's bit 7 differs.
- R4: Opcode 6 computes acc−operand−carry into the accumulator. Carry is set when a borrow is needed and auxiliary carry when the low nibble needs a borrow. Overflow is set when the inputs differ in bit 7 and the result's bit 7 differs from the accumulator's.
- R5: Opcodes 7, 8 and 9 put acc AND, OR and XOR operand into the accumulator. Opcode 10 puts the inverted operand there. None of them changes a flag.
- R6: Opcodes 11 and 12 increment and decrement the accumulator modulo 256. Opcodes 13 and 14 show operand+1 and operand−1 (modulo 256) on `resultOut` and leave the accumulator and working register unchanged. None of them changes a flag.
- R7: Opcode 15 rotates the accumulator left and opcode 17 rotates it right. Opcode 16 rotates left through carry (bit 7 goes to carry, carry to bit 0). Opcode 18 rotates right through carry (bit 0 goes to carry, carry to bit 7).
- R8: Opcode 19 exchanges the accumulator nibbles. Opcode 20 clears the accumulator and opcode 21 inverts it. Flags are unchanged.
- R9: Opcode 22 applies a decimal adjust in two steps. First, 0x06 is added when the low nibble exceeds 9 or auxiliary carry is set. Then 0x60 is added when the high nibble of that result exceeds 9 or carry is set or either step carries out. Carry is set by any carry out and is never cleared.
- R10: Opcode 23 multiplies acc by the operand. The low byte goes to the accumulator and the high byte to the working register, and also appears on `hiOut` in the same cycle. Carry is cleared and overflow is set exactly when the product exceeds 255.
- R11: Opcode 24 divides acc by the operand, putting the quotient in the accumulator and the remainder in the working register, and clears carry and overflow. With a zero divisor it sets overflow, clears carry and leaves both registers unchanged.
- R12: `parityOut` is 1 exactly when the accumulator holds an odd number of ones.
- R13: With `opValid` low, or with opcode 0 or 25 to 31, no register or flag changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| opValid | input | 1 | Perform the opcode on this edge |
| opCode | input | 5 | Operation select |
| opndSel | input | 1 | Operand source: 0 working register, 1 external |
| extIn | input | DATA_W | External operand byte |
| resultOut | output | DATA_W | Combinational primary result of the current opcode |
| hiOut | output | DATA_W | Combinational second byte (product high or remainder) |
| accOut | output | DATA_W | Accumulator |
| bOut | output | DATA_W | Working register |
| carryOut | output | 1 | Carry flag |
| auxOut | output | 1 | Auxiliary carry flag |
| ovOut | output | 1 | Overflow flag |
| parityOut | output | 1 | Odd parity of the accumulator |

## Verification
The bench builds the block with its default 8-bit data width. At that width the stimulus can cover every operand value, and the nibble thresholds of the decimal adjust, the full 16-bit product range and every divisor, including zero, are all reachable. Random opcodes, including the unused codes, run with random operand sources and occasional idle cycles. They are mixed with directed cases for signed overflow, carry wrap, BCD correction and the multiply and divide extremes.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int OP_W = 5;

  localparam logic [OP_W-1:0] OP_NOP   = 5'd0;
  localparam logic [OP_W-1:0] OP_LDA   = 5'd1;
  localparam logic [OP_W-1:0] OP_LDB   = 5'd2;
  localparam logic [OP_W-1:0] OP_LDPSW = 5'd3;
  localparam logic [OP_W-1:0] OP_ADD   = 5'd4;
  localparam logic [OP_W-1:0] OP_ADDC  = 5'd5;
  localparam logic [OP_W-1:0] OP_SUBB  = 5'd6;
  localparam logic [OP_W-1:0] OP_AND   = 5'd7;
  localparam logic [OP_W-1:0] OP_OR    = 5'd8;
  localparam logic [OP_W-1:0] OP_XOR   = 5'd9;
  localparam logic [OP_W-1:0] OP_NOT   = 5'd10;
  localparam logic [OP_W-1:0] OP_INCA  = 5'd11;
  localparam logic [OP_W-1:0] OP_DECA  = 5'd12;
  localparam logic [OP_W-1:0] OP_INCX  = 5'd13;
  localparam logic [OP_W-1:0] OP_DECX  = 5'd14;
  localparam logic [OP_W-1:0] OP_RL    = 5'd15;
  localparam logic [OP_W-1:0] OP_RLC   = 5'd16;
  localparam logic [OP_W-1:0] OP_RR    = 5'd17;
  localparam logic [OP_W-1:0] OP_RRC   = 5'd18;
  localparam logic [OP_W-1:0] OP_SWAP  = 5'd19;
  localparam logic [OP_W-1:0] OP_CLR   = 5'd20;
  localparam logic [OP_W-1:0] OP_CPL   = 5'd21;
  localparam logic [OP_W-1:0] OP_DA    = 5'd22;
  localparam logic [OP_W-1:0] OP_MUL   = 5'd23;
  localparam logic [OP_W-1:0] OP_DIV   = 5'd24;

  typedef enum logic [4:0] {
    SRC_PASS, SRC_OPND, SRC_ADD, SRC_SUB, SRC_AND, SRC_OR, SRC_XOR,
    SRC_NOT, SRC_INC, SRC_DEC, SRC_RL, SRC_RLC, SRC_RR, SRC_RRC,
    SRC_SWAP, SRC_ZERO, SRC_CPL, SRC_DA, SRC_MUL, SRC_DIV
  } resSel_e;

  typedef enum logic [1:0] {
    BSRC_OPND, BSRC_HI
  } bSel_e;

  typedef struct packed {
    logic    accWe;
    logic    bWe;
    logic    pswLoad;
    logic    cyWe;
    logic    acWe;
    logic    ovWe;
    logic    useCarryIn;
    logic    incOnOpnd;
    resSel_e resSel;
    bSel_e   bSel;
  } aluCtl_t;

endpackage

// File: rtl/acc_alu_ctrl.sv
module acc_alu_ctrl
  import acc_alu_pkg::*;
(
  input  logic            opValid,
  input  logic [OP_W-1:0] opCode,
  output aluCtl_t         ctl
);

  always_comb begin
    ctl        = '0;
    ctl.resSel = SRC_PASS;
    ctl.bSel   = BSRC_OPND;
    case (opCode)
      OP_LDA:   begin ctl.resSel = SRC_OPND; ctl.accWe = 1'b1; end
      OP_LDB:   begin ctl.bWe = 1'b1; ctl.bSel = BSRC_OPND; end
      OP_LDPSW: ctl.pswLoad = 1'b1;
      OP_ADD: begin
        ctl.resSel = SRC_ADD; ctl.accWe = 1'b1;
        ctl.cyWe = 1'b1; ctl.acWe = 1'b1; ctl.ovWe = 1'b1;
      end
      OP_ADDC: begin
        ctl.resSel = SRC_ADD; ctl.accWe = 1'b1; ctl.useCarryIn = 1'b1;
        ctl.cyWe = 1'b1; ctl.acWe = 1'b1; ctl.ovWe = 1'b1;
      end
      OP_SUBB: begin
        ctl.resSel = SRC_SUB; ctl.accWe = 1'b1; ctl.useCarryIn = 1'b1;
        ctl.cyWe = 1'b1; ctl.acWe = 1'b1; ctl.ovWe = 1'b1;
      end
      OP_AND:   begin ctl.resSel = SRC_AND;  ctl.accWe = 1'b1; end
      OP_OR:    begin ctl.resSel = SRC_OR;   ctl.accWe = 1'b1; end
      OP_XOR:   begin ctl.resSel = SRC_XOR;  ctl.accWe = 1'b1; end
      OP_NOT:   begin ctl.resSel = SRC_NOT;  ctl.accWe = 1'b1; end
      OP_INCA:  begin ctl.resSel = SRC_INC;  ctl.accWe = 1'b1; end
      OP_DECA:  begin ctl.resSel = SRC_DEC;  ctl.accWe = 1'b1; end
      OP_INCX:  begin ctl.resSel = SRC_INC;  ctl.incOnOpnd = 1'b1; end
      OP_DECX:  begin ctl.resSel = SRC_DEC;  ctl.incOnOpnd = 1'b1; end
      OP_RL:    begin ctl.resSel = SRC_RL;   ctl.accWe = 1'b1; end
      OP_RLC:   begin ctl.resSel = SRC_RLC;  ctl.accWe = 1'b1; ctl.cyWe = 1'b1; end
      OP_RR:    begin ctl.resSel = SRC_RR;   ctl.accWe = 1'b1; end
      OP_RRC:   begin ctl.resSel = SRC_RRC;  ctl.accWe = 1'b1; ctl.cyWe = 1'b1; end
      OP_SWAP:  begin ctl.resSel = SRC_SWAP; ctl.accWe = 1'b1; end
      OP_CLR:   begin ctl.resSel = SRC_ZERO; ctl.accWe = 1'b1; end
      OP_CPL:   begin ctl.resSel = SRC_CPL;  ctl.accWe = 1'b1; end
      OP_DA:    begin ctl.resSel = SRC_DA;   ctl.accWe = 1'b1; ctl.cyWe = 1'b1; end
      OP_MUL: begin
        ctl.resSel = SRC_MUL; ctl.accWe = 1'b1; ctl.bWe = 1'b1;
        ctl.bSel = BSRC_HI; ctl.cyWe = 1'b1; ctl.ovWe = 1'b1;
      end
      OP_DIV: begin
        ctl.resSel = SRC_DIV; ctl.accWe = 1'b1; ctl.bWe = 1'b1;
        ctl.bSel = BSRC_HI; ctl.cyWe = 1'b1; ctl.ovWe = 1'b1;
      end
      default: ctl.resSel = SRC_PASS;
    endcase
    if (!opValid) begin
      ctl.accWe   = 1'b0;
      ctl.bWe     = 1'b0;
      ctl.pswLoad = 1'b0;
      ctl.cyWe    = 1'b0;
      ctl.acWe    = 1'b0;
      ctl.ovWe    = 1'b0;
    end
  end

endmodule

// File: rtl/acc_alu_datapath.sv
module acc_alu_datapath
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  aluCtl_t           ctl,
  input  logic              opndSel,
  input  logic [DATA_W-1:0] extIn,
  output logic [DATA_W-1:0] resultOut,
  output logic [DATA_W-1:0] hiOut,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] bOut,
  output logic              carryOut,
  output logic              auxOut,
  output logic              ovOut,
  output logic              parityOut
);

  localparam int MSB    = DATA_W - 1;
  localparam int NIB_W  = DATA_W / 2;
  localparam int PROD_W = 2 * DATA_W;
  localparam logic [NIB_W-1:0]  DEC_LIMIT = NIB_W'(9);
  localparam logic [NIB_W:0]    NIB_MAX   = {1'b0, {NIB_W{1'b1}}};
  localparam logic [DATA_W-1:0] LOW_FIX   = DATA_W'(6);
  localparam logic [DATA_W-1:0] HIGH_FIX  = LOW_FIX << NIB_W;

  logic [DATA_W-1:0] accQ, bQ, opnd, incBase, quot, rem, res, hiRes;
  logic              cyQ, acQ, ovQ, cin;
  logic [DATA_W:0]   sumW, diffW, daStep1, daStep2;
  logic [NIB_W:0]    sumLo, subLoRhs;
  logic [PROD_W-1:0] prod;
  logic              addAux, subAux, addOv, subOv;
  logic              lowFix, highFix, daCarry, divZero;
  logic              cyNext, acNext, ovNext;

  assign opnd = opndSel ? extIn : bQ;
  assign cin  = ctl.useCarryIn & cyQ;

  // adder and subtractor share the carry-in
  assign sumW     = {1'b0, accQ} + {1'b0, opnd} + {{DATA_W{1'b0}}, cin};
  assign diffW    = {1'b0, accQ} - {1'b0, opnd} - {{DATA_W{1'b0}}, cin};
  assign sumLo    = {1'b0, accQ[NIB_W-1:0]} + {1'b0, opnd[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
  assign subLoRhs = {1'b0, opnd[NIB_W-1:0]} + {{NIB_W{1'b0}}, cin};
  assign addAux   = sumLo > NIB_MAX;
  assign subAux   = {1'b0, accQ[NIB_W-1:0]} < subLoRhs;
  assign addOv    = (accQ[MSB] == opnd[MSB]) && (sumW[MSB] != accQ[MSB]);
  assign subOv    = (accQ[MSB] != opnd[MSB]) && (diffW[MSB] != accQ[MSB]);

  assign incBase = ctl.incOnOpnd ? opnd : accQ;

  // two-step BCD correction
  assign lowFix  = (accQ[NIB_W-1:0] > DEC_LIMIT) || acQ;
  assign daStep1 = {1'b0, accQ} + (lowFix ? {1'b0, LOW_FIX} : '0);
  assign highFix = (daStep1[MSB:NIB_W] > DEC_LIMIT) || cyQ || daStep1[DATA_W];
  assign daStep2 = {1'b0, daStep1[MSB:0]} + (highFix ? {1'b0, HIGH_FIX} : '0);
  assign daCarry = cyQ | daStep1[DATA_W] | daStep2[DATA_W];

  assign prod    = PROD_W'(accQ) * PROD_W'(opnd);
  assign divZero = (ctl.resSel == SRC_DIV) && (opnd == '0);
  assign quot    = (opnd == '0) ? '0 : accQ / opnd;
  assign rem     = (opnd == '0) ? '0 : accQ % opnd;

  always_comb begin
    case (ctl.resSel)
      SRC_OPND: res = opnd;
      SRC_ADD:  res = sumW[MSB:0];
      SRC_SUB:  res = diffW[MSB:0];
      SRC_AND:  res = accQ & opnd;
      SRC_OR:   res = accQ | opnd;
      SRC_XOR:  res = accQ ^ opnd;
      SRC_NOT:  res = ~opnd;
      SRC_INC:  res = incBase + DATA_W'(1);
      SRC_DEC:  res = incBase - DATA_W'(1);
      SRC_RL:   res = {accQ[MSB-1:0], accQ[MSB]};
      SRC_RLC:  res = {accQ[MSB-1:0], cyQ};
      SRC_RR:   res = {accQ[0], accQ[MSB:1]};
      SRC_RRC:  res = {cyQ, accQ[MSB:1]};
      SRC_SWAP: res = {accQ[NIB_W-1:0], accQ[MSB:NIB_W]};
      SRC_ZERO: res = '0;
      SRC_CPL:  res = ~accQ;
      SRC_DA:   res = daStep2[MSB:0];
      SRC_MUL:  res = prod[MSB:0];
      SRC_DIV:  res = quot;
      default:  res = accQ;
    endcase
  end

  always_comb begin
    case (ctl.resSel)
      SRC_MUL: hiRes = prod[PROD_W-1:DATA_W];
      SRC_DIV: hiRes = rem;
      default: hiRes = '0;
    endcase
  end

  always_comb begin
    cyNext = cyQ;
    acNext = acQ;
    ovNext = ovQ;
    case (ctl.resSel)
      SRC_ADD: begin cyNext = sumW[DATA_W];  acNext = addAux; ovNext = addOv; end
      SRC_SUB: begin cyNext = diffW[DATA_W]; acNext = subAux; ovNext = subOv; end
      SRC_RLC: cyNext = accQ[MSB];
      SRC_RRC: cyNext = accQ[0];
      SRC_DA:  cyNext = daCarry;
      SRC_MUL: begin cyNext = 1'b0; ovNext = |prod[PROD_W-1:DATA_W]; end
      SRC_DIV: begin cyNext = 1'b0; ovNext = divZero; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accQ <= '0;
      bQ   <= '0;
    end else begin
      if (ctl.accWe && !divZero) accQ <= res;
      if (ctl.bWe && !divZero) bQ <= (ctl.bSel == BSRC_HI) ? hiRes : opnd;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cyQ <= 1'b0;
      acQ <= 1'b0;
      ovQ <= 1'b0;
    end else if (ctl.pswLoad) begin
      cyQ <= opnd[MSB];
      acQ <= opnd[MSB-1];
      ovQ <= opnd[2];
    end else begin
      if (ctl.cyWe) cyQ <= cyNext;
      if (ctl.acWe) acQ <= acNext;
      if (ctl.ovWe) ovQ <= ovNext;
    end
  end

  assign resultOut = res;
  assign hiOut     = hiRes;
  assign accOut    = accQ;
  assign bOut      = bQ;
  assign carryOut  = cyQ;
  assign auxOut    = acQ;
  assign ovOut     = ovQ;
  assign parityOut = ^accQ;

  p_mul_flags_r10: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.accWe && ctl.resSel == SRC_MUL) |=> (!carryOut && (ovOut == (bOut != '0))));

  p_div_zero_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.accWe && divZero) |=> (ovOut && !carryOut && accOut == $past(accOut) && bOut == $past(bOut)));

  p_idle_stable_r13: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.accWe && !ctl.bWe && !ctl.pswLoad && !ctl.cyWe && !ctl.acWe && !ctl.ovWe)
    |=> ($stable(accOut) && $stable(bOut) && $stable(carryOut) && $stable(auxOut) && $stable(ovOut)));

  p_swap_nibbles_r8: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.accWe && ctl.resSel == SRC_SWAP)
    |=> (accOut == {$past(accOut[NIB_W-1:0]), $past(accOut[MSB:NIB_W])}));

  p_load_parity_r12: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.accWe && ctl.resSel == SRC_OPND) |=> (parityOut == ^$past(opnd)));

  p_rlc_carry_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.accWe && ctl.resSel == SRC_RLC) |=> (carryOut == $past(accOut[MSB]) && accOut[0] == $past(carryOut)));

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [OP_W-1:0]   opCode,
  input  logic              opndSel,
  input  logic [DATA_W-1:0] extIn,
  output logic [DATA_W-1:0] resultOut,
  output logic [DATA_W-1:0] hiOut,
  output logic [DATA_W-1:0] accOut,
  output logic [DATA_W-1:0] bOut,
  output logic              carryOut,
  output logic              auxOut,
  output logic              ovOut,
  output logic              parityOut
);

  aluCtl_t ctl;

  acc_alu_ctrl u_ctrl (
    .opValid (opValid),
    .opCode  (opCode),
    .ctl     (ctl)
  );

  acc_alu_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .opndSel   (opndSel),
    .extIn     (extIn),
    .resultOut (resultOut),
    .hiOut     (hiOut),
    .accOut    (accOut),
    .bOut      (bOut),
    .carryOut  (carryOut),
    .auxOut    (auxOut),
    .ovOut     (ovOut),
    .parityOut (parityOut)
  );

endmodule

// File: tb/acc_alu_tb.sv
module acc_alu_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       opValid = 1'b0;
  logic [4:0] opCode = '0;
  logic       opndSel = 1'b0;
  logic [7:0] extIn = '0;
  logic [7:0] resultOut, hiOut, accOut, bOut;
  logic       carryOut, auxOut, ovOut, parityOut;

  int checks = 0;
  int fails = 0;
  int ra = 0, rb = 0, rcy = 0, rac = 0, rov = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  acc_alu u_dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .opndSel(opndSel), .extIn(extIn), .resultOut(resultOut), .hiOut(hiOut),
    .accOut(accOut), .bOut(bOut), .carryOut(carryOut), .auxOut(auxOut),
    .ovOut(ovOut), .parityOut(parityOut)
  );

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic string reqTag(input int op);
    if (op >= 1 && op <= 3) return "R2";
    if (op == 4 || op == 5) return "R3";
    if (op == 6) return "R4";
    if (op >= 7 && op <= 10) return "R5";
    if (op >= 11 && op <= 14) return "R6";
    if (op >= 15 && op <= 18) return "R7";
    if (op >= 19 && op <= 21) return "R8";
    if (op == 22) return "R9";
    if (op == 23) return "R10";
    if (op == 24) return "R11";
    return "R13";
  endfunction

  function automatic int oddOnes(input int v);
    int n = 0;
    for (int i = 0; i < 8; i++) n += (v >> i) & 1;
    return n % 2;
  endfunction

  task automatic compareState(input string tag);
    check(tag, "acc", int'(accOut), ra);
    check(tag, "b", int'(bOut), rb);
    check(tag, "flags", int'({carryOut, auxOut, ovOut}), (rcy << 2) | (rac << 1) | rov);
    check("R12", "parity", int'(parityOut), oddOnes(ra));
  endtask

  task automatic runOp(input int op, input bit sel, input int ext, input bit valid);
    int o, na, nb, ncy, nac, nov, t, cin;
    string tag;
    @(negedge clk);
    opValid = valid;
    opCode  = 5'(op);
    opndSel = sel;
    extIn   = 8'(ext);
    o   = sel ? (ext & 255) : rb;
    tag = valid ? reqTag(op) : "R13";
    na = ra; nb = rb; ncy = rcy; nac = rac; nov = rov;
    if (valid) begin
      case (op)
        1: na = o;
        2: nb = o;
        3: begin ncy = (o >> 7) & 1; nac = (o >> 6) & 1; nov = (o >> 2) & 1; end
        4, 5: begin
          cin = (op == 5) ? rcy : 0;
          t = ra + o + cin;
          ncy = (t > 255) ? 1 : 0;
          nac = ((ra & 15) + (o & 15) + cin > 15) ? 1 : 0;
          nov = (((ra >> 7) == (o >> 7)) && (((t >> 7) & 1) != (ra >> 7))) ? 1 : 0;
          na = t & 255;
        end
        6: begin
          t = ra - o - rcy;
          ncy = (t < 0) ? 1 : 0;
          nac = ((ra & 15) < (o & 15) + rcy) ? 1 : 0;
          na = t & 255;
          nov = (((ra >> 7) != (o >> 7)) && ((na >> 7) != (ra >> 7))) ? 1 : 0;
        end
        7:  na = ra & o;
        8:  na = ra | o;
        9:  na = ra ^ o;
        10: na = (~o) & 255;
        11: na = (ra + 1) & 255;
        12: na = (ra + 255) & 255;
        15: na = ((ra << 1) | (ra >> 7)) & 255;
        16: begin na = ((ra << 1) | rcy) & 255; ncy = ra >> 7; end
        17: na = ((ra >> 1) | ((ra & 1) << 7)) & 255;
        18: begin na = (ra >> 1) | (rcy << 7); ncy = ra & 1; end
        19: na = ((ra << 4) | (ra >> 4)) & 255;
        20: na = 0;
        21: na = (~ra) & 255;
        22: begin
          t = ra;
          if ((t & 15) > 9 || rac == 1) t += 6;
          if (t > 255) ncy = 1;
          t &= 255;
          if ((t >> 4) > 9 || ncy == 1) t += 96;
          if (t > 255) ncy = 1;
          na = t & 255;
        end
        23: begin
          t = ra * o;
          na = t & 255; nb = t >> 8; ncy = 0; nov = (t > 255) ? 1 : 0;
        end
        24: begin
          ncy = 0;
          if (o == 0) nov = 1;
          else begin na = ra / o; nb = ra % o; nov = 0; end
        end
        default: ;
      endcase
    end
    #1;
    if (valid && op == 13) check("R6", "resultOut inc", int'(resultOut), (o + 1) & 255);
    if (valid && op == 14) check("R6", "resultOut dec", int'(resultOut), (o + 255) & 255);
    if (valid && op == 23) check("R10", "hiOut", int'(hiOut), (ra * o) >> 8);
    @(negedge clk);
    opValid = 1'b0;
    ra = na; rb = nb; rcy = ncy; rac = nac; rov = nov;
    compareState(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    repeat (3) @(negedge clk);
    // R1: reset state
    compareState("R1");
    rstN = 1'b1;
    @(negedge clk);
    compareState("R1");

    // R3: signed overflow and half carry, then carry wrap
    runOp(1, 1, 8'h7F, 1);
    runOp(4, 1, 8'h01, 1);
    runOp(1, 1, 8'hFF, 1);
    runOp(4, 1, 8'h01, 1);
    runOp(5, 1, 8'h10, 1);
    // R4: borrow with overflow
    runOp(3, 1, 8'h00, 1);
    runOp(1, 1, 8'h80, 1);
    runOp(6, 1, 8'h01, 1);
    runOp(3, 1, 8'h80, 1);
    runOp(1, 1, 8'h00, 1);
    runOp(6, 1, 8'h00, 1);
    // R9: BCD 49+38 and 99+01
    runOp(3, 1, 8'h00, 1);
    runOp(1, 1, 8'h49, 1);
    runOp(4, 1, 8'h38, 1);
    runOp(22, 1, 0, 1);
    runOp(1, 1, 8'h99, 1);
    runOp(4, 1, 8'h01, 1);
    runOp(22, 1, 0, 1);
    // R10: largest product and 16x16
    runOp(1, 1, 8'hFF, 1);
    runOp(2, 1, 8'hFF, 1);
    runOp(23, 0, 0, 1);
    runOp(1, 1, 8'h10, 1);
    runOp(23, 1, 8'h10, 1);
    runOp(1, 1, 8'h0F, 1);
    runOp(23, 1, 8'h11, 1);
    // R11: divide and divide by zero
    runOp(1, 1, 8'd251, 1);
    runOp(24, 1, 8'd7, 1);
    runOp(3, 1, 8'h80, 1);
    runOp(24, 1, 8'd0, 1);
    // R7: rotates through carry
    runOp(1, 1, 8'h81, 1);
    runOp(16, 1, 0, 1);
    runOp(18, 1, 0, 1);
    runOp(15, 1, 0, 1);
    runOp(17, 1, 0, 1);
    // R6: wrap and external inc/dec
    runOp(1, 1, 8'hFF, 1);
    runOp(11, 1, 0, 1);
    runOp(12, 1, 0, 1);
    runOp(13, 1, 8'hFF, 1);
    runOp(14, 1, 8'h00, 1);
    // R13: idle and unused codes
    runOp(4, 1, 8'h55, 0);
    runOp(0, 1, 8'h55, 1);
    runOp(31, 1, 8'h55, 1);

    for (int i = 0; i < 4000; i++) begin
      int op;
      op = int'($urandom_range(0, 31));
      runOp(op, 1'($urandom_range(0, 1)), int'($urandom_range(0, 255)),
            ($urandom_range(0, 9) != 0));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule